// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block produces the bus-cycle sequence that an 8-bit processor core runs when it takes an interrupt. At an instruction boundary it looks at a non-maskable request and a maskable request. It then picks one response kind: non-maskable, maskable mode 0, mode 1 or mode 2. It steps through that kind's list of machine cycles one clock per T-state. Each clock it shows which cycle is running and the T-state within it.

During stack cycles the block supplies the stack address and the byte of the interrupted program counter to write. During table cycles it supplies the vector-table address. Bytes returned by the interrupting device or by memory are sampled in the last T-state of each read cycle. When the sequence ends, the block pulses a completion strobe and presents the new program counter and stack pointer. When a response is accepted, the block pulses a request to clear the interrupt enable flag. The core uses these to continue execution.

Top module: `irq_ack_seq`

## Requirements
- R1: A non-maskable request seen at a boundary wins over any maskable request, whatever the enable flag. It runs a 5 T discarded-opcode fetch (cycle code 1), then a 3 T stack-high write (code 5), then a 3 T stack-low write (code 6). The new PC is 0x0066.
- R2: A maskable request with no non-maskable request is accepted only when `ie_i` is 1. Otherwise the block stays idle (code 0, `busy_o` low).
- R3: Requests are taken only on a clock where `boundary_i` is 1 and the block is idle. Requests that arrive while a sequence is running do not change that sequence.
- R4: Mode 1 (`mode_i` = 1, and also `mode_i` = 3) runs a 7 T acknowledge cycle (code 2), then 3 T stack-high and stack-low writes. The new PC is 0x0038.
- R5: Mode 2 (`mode_i` = 2) runs a 7 T acknowledge cycle, then 3 T stack-high and stack-low writes. It then runs a 3 T table read of the low target byte (code 7) at {vector, acknowledged byte with bit 0 cleared}, followed by a 3 T read of the high byte (code 8) at that address + 1. The new PC is {high, low}.
- R6: Mode 0 (`mode_i` = 0) runs a 6 T acknowledge cycle. If the acknowledged byte is not 0xCD, it then runs 3 T stack-high and stack-low writes, and the new PC is the byte ANDed with 0x38.
- R7: In mode 0 with acknowledged byte 0xCD, the block runs a 3 T operand-low read (code 3), a 4 T operand-high read (code 4), then 3 T stack-high and stack-low writes. The new PC is {operand high, operand low}.
- R8: In the stack-high cycle `addr_o` = SP-1 and `wdata_o` = PC[15:8]. In the stack-low cycle `addr_o` = SP-2 and `wdata_o` = PC[7:0]. `wr_o` is high in exactly these T-states. The new SP is SP-2. PC and SP are the values at acceptance.
- R9: `tstate_o` counts 1..N through each cycle of N T-states and is 0 when idle. `ack_o` is high exactly during acknowledge cycles. `rd_o` is high exactly during table reads.
- R10: `ie_clr_o` is high for one clock, in the first T-state of an accepted response. `done_o` is high for one clock, the clock after the last T-state, with `new_pc_o` and `new_sp_o` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary, requests sampled here |
| nmi_i | input | 1 | Non-maskable request |
| irq_i | input | 1 | Maskable request |
| ie_i | input | 1 | Interrupt enable flag |
| mode_i | input | 2 | Maskable response mode |
| pc_i | input | 16 | Program counter to save |
| sp_i | input | 16 | Stack pointer before the pushes |
| vec_i | input | 8 | Vector register, high byte of the table address |
| data_i | input | 8 | Byte returned by device or memory |
| cyc_o | output | 4 | Current cycle code |
| tstate_o | output | 3 | T-state index within the cycle |
| ack_o | output | 1 | Acknowledge strobe |
| busy_o | output | 1 | Sequence in progress |
| wr_o | output | 1 | Stack write strobe |
| rd_o | output | 1 | Vector-table read strobe |
| addr_o | output | 16 | Stack or table address |
| wdata_o | output | 8 | Stack write byte |
| ie_clr_o | output | 1 | Request to clear the enable flag |
| done_o | output | 1 | Sequence finished |
| new_pc_o | output | 16 | Program counter to resume at |
| new_sp_o | output | 16 | Stack pointer after the pushes |

## Verification
The assertions assume that `boundary_i` is never high while a sequence is running, unless the bench is deliberately exercising the ignore rule. They also assume that `data_i` holds a settled byte in the last T-state of every read cycle. The bench respects both assumptions. It raises the boundary for one clock to start a response and drops it at least one clock before completion. It changes `data_i` only at falling edges, choosing the byte from the cycle code it observes. Random trials draw the mode, the request mix, the enable flag and the data bytes. They bias the acknowledged byte towards 0xCD so that the mode 0 call path is hit often.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [3:0] {
        CY_IDLE = 4'd0,
        CY_NMIF = 4'd1,
        CY_ACK  = 4'd2,
        CY_OPL  = 4'd3,
        CY_OPH  = 4'd4,
        CY_STH  = 4'd5,
        CY_STL  = 4'd6,
        CY_TBL  = 4'd7,
        CY_TBH  = 4'd8
    } cyc_e;

    typedef enum logic [1:0] {
        K_NMI = 2'd0,
        K_M0  = 2'd1,
        K_M1  = 2'd2,
        K_M2  = 2'd3
    } kind_e;

endpackage

// File: rtl/irq_ack_arb.sv
module irq_ack_arb
    import irq_ack_pkg::*;
(
    input  logic       idle_i,
    input  logic       boundary_i,
    input  logic       nmi_i,
    input  logic       irq_i,
    input  logic       ie_i,
    input  logic [1:0] mode_i,
    output logic       accept_o,
    output kind_e      kind_o
);

    always_comb begin
        accept_o = idle_i && boundary_i && (nmi_i || (irq_i && ie_i));
        if (nmi_i) begin
            kind_o = K_NMI;
        end else begin
            case (mode_i)
                2'd0:    kind_o = K_M0;
                2'd2:    kind_o = K_M2;
                default: kind_o = K_M1;
            endcase
        end
    end

endmodule

// File: rtl/irq_ack_plan.sv
module irq_ack_plan
    import irq_ack_pkg::*;
#(
    parameter int TW       = 3,
    parameter int LEN_NMIF = 5,
    parameter int LEN_ACK0 = 6,
    parameter int LEN_ACK  = 7,
    parameter int LEN_OPL  = 3,
    parameter int LEN_OPH  = 4,
    parameter int LEN_STK  = 3,
    parameter int LEN_TBL  = 3
) (
    input  cyc_e          cyc_i,
    input  kind_e         kind_i,
    input  kind_e         new_kind_i,
    input  logic          call_i,
    output cyc_e          first_o,
    output cyc_e          next_o,
    output logic [TW-1:0] len_o
);

    always_comb begin
        first_o = (new_kind_i == K_NMI) ? CY_NMIF : CY_ACK;

        case (cyc_i)
            CY_NMIF: len_o = TW'(LEN_NMIF);
            CY_ACK:  len_o = (kind_i == K_M0) ? TW'(LEN_ACK0) : TW'(LEN_ACK);
            CY_OPL:  len_o = TW'(LEN_OPL);
            CY_OPH:  len_o = TW'(LEN_OPH);
            CY_STH,
            CY_STL:  len_o = TW'(LEN_STK);
            CY_TBL,
            CY_TBH:  len_o = TW'(LEN_TBL);
            default: len_o = '0;
        endcase

        case (cyc_i)
            CY_NMIF: next_o = CY_STH;
            CY_ACK:  next_o = (kind_i == K_M0 && call_i) ? CY_OPL : CY_STH;
            CY_OPL:  next_o = CY_OPH;
            CY_OPH:  next_o = CY_STH;
            CY_STH:  next_o = CY_STL;
            CY_STL:  next_o = (kind_i == K_M2) ? CY_TBL : CY_IDLE;
            CY_TBL:  next_o = CY_TBH;
            default: next_o = CY_IDLE;
        endcase
    end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          AW       = 16,
    parameter int          TW       = 3,
    parameter logic [15:0] NMI_VEC  = 16'h0066,
    parameter logic [15:0] M1_VEC   = 16'h0038,
    parameter logic [7:0]  CALL_OP  = 8'hCD,
    parameter logic [7:0]  RST_MASK = 8'h38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary_i,
    input  logic          nmi_i,
    input  logic          irq_i,
    input  logic          ie_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] sp_i,
    input  logic [DW-1:0] vec_i,
    input  logic [DW-1:0] data_i,
    output logic [3:0]    cyc_o,
    output logic [TW-1:0] tstate_o,
    output logic          ack_o,
    output logic          busy_o,
    output logic          wr_o,
    output logic          rd_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          ie_clr_o,
    output logic          done_o,
    output logic [AW-1:0] new_pc_o,
    output logic [AW-1:0] new_sp_o
);

    localparam int HW = AW - DW;

    typedef struct packed {
        cyc_e          cyc;
        logic [TW-1:0] ts;
        kind_e         kind;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] tgt;
        logic [AW-1:0] tbl;
        logic          ie_clr;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    logic          accept;
    kind_e         new_kind;
    cyc_e          first_cyc, next_cyc;
    logic [TW-1:0] cyc_len;
    logic          is_call;
    logic          last_t;

    assign is_call = (data_i == CALL_OP);

    irq_ack_arb u_arb (
        .idle_i     (st_q.cyc == CY_IDLE),
        .boundary_i (boundary_i),
        .nmi_i      (nmi_i),
        .irq_i      (irq_i),
        .ie_i       (ie_i),
        .mode_i     (mode_i),
        .accept_o   (accept),
        .kind_o     (new_kind)
    );

    irq_ack_plan #(.TW(TW)) u_plan (
        .cyc_i      (st_q.cyc),
        .kind_i     (st_q.kind),
        .new_kind_i (new_kind),
        .call_i     (is_call),
        .first_o    (first_cyc),
        .next_o     (next_cyc),
        .len_o      (cyc_len)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ie_clr = 1'b0;
        st_d.done   = 1'b0;
        last_t      = (st_q.cyc != CY_IDLE) && (st_q.ts == cyc_len);

        if (st_q.cyc == CY_IDLE) begin
            if (accept) begin
                st_d.cyc    = first_cyc;
                st_d.ts     = TW'(1);
                st_d.kind   = new_kind;
                st_d.pc     = pc_i;
                st_d.sp     = sp_i;
                st_d.ie_clr = 1'b1;
                case (new_kind)
                    K_NMI:   st_d.tgt = AW'(NMI_VEC);
                    K_M1:    st_d.tgt = AW'(M1_VEC);
                    default: st_d.tgt = '0;
                endcase
            end
        end else if (last_t) begin
            case (st_q.cyc)
                CY_ACK: begin
                    if (st_q.kind == K_M0 && !is_call) begin
                        st_d.tgt = {{HW{1'b0}}, data_i & RST_MASK};
                    end
                    if (st_q.kind == K_M2) begin
                        st_d.tbl = {vec_i, data_i[DW-1:1], 1'b0};
                    end
                end
                CY_OPL, CY_TBL: st_d.tgt[DW-1:0]  = data_i;
                CY_OPH, CY_TBH: st_d.tgt[AW-1:DW] = data_i;
                default: ;
            endcase
            st_d.cyc  = next_cyc;
            st_d.ts   = (next_cyc == CY_IDLE) ? '0 : TW'(1);
            st_d.done = (next_cyc == CY_IDLE);
        end else begin
            st_d.ts = st_q.ts + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cyc: CY_IDLE, ts: '0, kind: K_NMI, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cyc_o    = st_q.cyc;
        tstate_o = st_q.ts;
        ack_o    = (st_q.cyc == CY_ACK);
        busy_o   = (st_q.cyc != CY_IDLE);
        wr_o     = (st_q.cyc == CY_STH) || (st_q.cyc == CY_STL);
        rd_o     = (st_q.cyc == CY_TBL) || (st_q.cyc == CY_TBH);
        ie_clr_o = st_q.ie_clr;
        done_o   = st_q.done;
        new_pc_o = st_q.tgt;
        new_sp_o = st_q.sp - AW'(2);
        addr_o   = '0;
        wdata_o  = '0;
        case (st_q.cyc)
            CY_STH: begin
                addr_o  = st_q.sp - AW'(1);
                wdata_o = st_q.pc[AW-1:DW];
            end
            CY_STL: begin
                addr_o  = st_q.sp - AW'(2);
                wdata_o = st_q.pc[DW-1:0];
            end
            CY_TBL: addr_o = st_q.tbl;
            CY_TBH: addr_o = st_q.tbl | AW'(1);
            default: ;
        endcase
    end

    // R1: non-maskable request wins at a boundary
    assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && boundary_i && nmi_i) |=> (cyc_o == CY_NMIF && tstate_o == TW'(1)));

    // R2: masked request leaves the block idle
    assert_masked_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !nmi_i && !ie_i) |=> !busy_o);

    // R3: nothing starts without a boundary
    assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !boundary_i) |=> !busy_o);

    // R9: T-state index stays within the cycle length
    assert_ts_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tstate_o >= TW'(1) && tstate_o <= cyc_len));

    // R8: low stack write directly follows the high one
    assert_stack_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == CY_STL && tstate_o == TW'(1)) |-> ($past(cyc_o) == CY_STH));

    // R5: table reads follow the stack writes
    assert_table_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == CY_TBL && tstate_o == TW'(1)) |-> ($past(cyc_o) == CY_STL));

    // R10: completion only after a final stack or table cycle
    assert_done_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cyc_o) == CY_STL || $past(cyc_o) == CY_TBH) && !busy_o);

    // R10: enable clear only at the start of a response
    assert_ie_clr_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr_o |-> ($past(!busy_o) && tstate_o == TW'(1)));

endmodule

// File: tb/irq_ack_seq_bench.sv
`timescale 1ns/1ps
module irq_ack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0, nmi_i = 1'b0, irq_i = 1'b0, ie_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [15:0] pc_i = '0, sp_i = '0;
    logic [7:0]  vec_i = '0, data_i = '0;
    logic [3:0]  cyc_o;
    logic [2:0]  tstate_o;
    logic        ack_o, busy_o, wr_o, rd_o, ie_clr_o, done_o;
    logic [15:0] addr_o, new_pc_o, new_sp_o;
    logic [7:0]  wdata_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_ack_seq u_irq_ack_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .nmi_i(nmi_i),
        .irq_i(irq_i), .ie_i(ie_i), .mode_i(mode_i), .pc_i(pc_i), .sp_i(sp_i),
        .vec_i(vec_i), .data_i(data_i), .cyc_o(cyc_o), .tstate_o(tstate_o),
        .ack_o(ack_o), .busy_o(busy_o), .wr_o(wr_o), .rd_o(rd_o),
        .addr_o(addr_o), .wdata_o(wdata_o), .ie_clr_o(ie_clr_o),
        .done_o(done_o), .new_pc_o(new_pc_o), .new_sp_o(new_sp_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pc(input bit nmi, input logic [1:0] mode,
            input logic [7:0] ab, lo, hi, mlo, mhi);
        if (nmi)                         return 16'h0066;
        if (mode == 2'd0 && ab == 8'hCD) return {hi, lo};
        if (mode == 2'd0)                return {8'h00, ab & 8'h38};
        if (mode == 2'd2)                return {mhi, mlo};
        return 16'h0038;
    endfunction

    task automatic run_case(input bit nmi, irq, ie, input logic [1:0] mode,
            input logic [15:0] pc, sp, input logic [7:0] vec, ab, lo, hi, mlo, mhi,
            input bit hold, input string tag);
        int n = 0;
        int cc[6];
        int ll[6];
        int trace_err = 0;
        int addr_err = 0;
        bit accept;
        logic [15:0] tbl;
        accept = nmi || (irq && ie);
        tbl = {vec, ab & 8'hFE};
        if (nmi) begin
            cc[0] = 1; ll[0] = 5; cc[1] = 5; ll[1] = 3; cc[2] = 6; ll[2] = 3; n = 3;
        end else if (mode == 2'd0 && ab == 8'hCD) begin
            cc[0] = 2; ll[0] = 6; cc[1] = 3; ll[1] = 3; cc[2] = 4; ll[2] = 4;
            cc[3] = 5; ll[3] = 3; cc[4] = 6; ll[4] = 3; n = 5;
        end else if (mode == 2'd0) begin
            cc[0] = 2; ll[0] = 6; cc[1] = 5; ll[1] = 3; cc[2] = 6; ll[2] = 3; n = 3;
        end else if (mode == 2'd2) begin
            cc[0] = 2; ll[0] = 7; cc[1] = 5; ll[1] = 3; cc[2] = 6; ll[2] = 3;
            cc[3] = 7; ll[3] = 3; cc[4] = 8; ll[4] = 3; n = 5;
        end else begin
            cc[0] = 2; ll[0] = 7; cc[1] = 5; ll[1] = 3; cc[2] = 6; ll[2] = 3; n = 3;
        end

        @(negedge clk);
        nmi_i = nmi; irq_i = irq; ie_i = ie; mode_i = mode;
        pc_i = pc; sp_i = sp; vec_i = vec; boundary_i = 1'b1;
        @(negedge clk);
        if (!hold) boundary_i = 1'b0;
        pc_i = ~pc; sp_i = ~sp;
        if (!accept) begin
            chk(busy_o == 1'b0 && ie_clr_o == 1'b0, {tag, " R2 masked stays idle"},
                {31'd0, busy_o}, 32'd0);
            boundary_i = 1'b0; nmi_i = 1'b0; irq_i = 1'b0;
            return;
        end
        chk(ie_clr_o == 1'b1, {tag, " R10 enable clear at first T"}, {31'd0, ie_clr_o}, 32'd1);
        for (int k = 0; k < n; k++) begin
            for (int t = 0; t < ll[k]; t++) begin
                case (cyc_o)
                    4'd2:    data_i = ab;
                    4'd3:    data_i = lo;
                    4'd4:    data_i = hi;
                    4'd7:    data_i = mlo;
                    4'd8:    data_i = mhi;
                    default: data_i = 8'h5A;
                endcase
                if (int'(cyc_o) != cc[k] || int'(tstate_o) != t + 1) trace_err++;
                if (ack_o != (cc[k] == 2) || rd_o != (cc[k] >= 7)) trace_err++;
                if (t > 0 && ie_clr_o) trace_err++;
                if (cc[k] == 5 && !(wr_o && addr_o == sp - 16'd1 && wdata_o == pc[15:8])) addr_err++;
                if (cc[k] == 6 && !(wr_o && addr_o == sp - 16'd2 && wdata_o == pc[7:0])) addr_err++;
                if (cc[k] == 7 && addr_o != tbl) addr_err++;
                if (cc[k] == 8 && addr_o != (tbl | 16'd1)) addr_err++;
                if (cc[k] < 5 && wr_o) addr_err++;
                if (k == n - 1 && t == ll[k] - 1) boundary_i = 1'b0;
                @(negedge clk);
            end
        end
        nmi_i = 1'b0; irq_i = 1'b0;
        chk(trace_err == 0, {tag, " R1/R4/R5/R6/R7/R9 cycle trace (R3 if held)"}, trace_err, 0);
        chk(addr_err == 0, {tag, " R8/R5 stack and table addresses"}, addr_err, 0);
        chk(done_o && !busy_o, {tag, " R10 done pulse"}, {done_o, busy_o}, 2'b10);
        chk(new_pc_o == exp_pc(nmi, mode, ab, lo, hi, mlo, mhi), {tag, " new PC R1 R4 R5 R6 R7"},
            new_pc_o, exp_pc(nmi, mode, ab, lo, hi, mlo, mhi));
        chk(new_sp_o == sp - 16'd2, {tag, " R8 new SP"}, new_sp_o, sp - 16'd2);
        @(negedge clk);
        chk(!done_o && !busy_o, {tag, " R10 done one clock"}, {done_o, busy_o}, 2'b00);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cyc_o == 4'd0 && tstate_o == 3'd0 && !busy_o && !done_o && !ie_clr_o,
            "reset idle R9", {cyc_o, 1'b0, tstate_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: request without boundary is ignored
        nmi_i = 1'b1; irq_i = 1'b1; ie_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !ie_clr_o, "no boundary R3", {31'd0, busy_o}, 32'd0);
        nmi_i = 1'b0; irq_i = 1'b0;

        run_case(1, 0, 0, 2'd1, 16'h1234, 16'h8000, 8'h00, 8'h00, 0, 0, 0, 0, 0, "nmi ie0 R1");
        run_case(1, 1, 1, 2'd2, 16'hABCD, 16'h0001, 8'h40, 8'h11, 0, 0, 8'h22, 8'h33, 0, "nmi beats irq R1");
        run_case(0, 1, 0, 2'd1, 16'h1111, 16'h2222, 8'h00, 8'h00, 0, 0, 0, 0, 0, "masked R2");
        run_case(0, 1, 1, 2'd1, 16'h0F0F, 16'hFFFE, 8'h00, 8'h00, 0, 0, 0, 0, 0, "mode1 R4");
        run_case(0, 1, 1, 2'd3, 16'h7777, 16'h1000, 8'h00, 8'h00, 0, 0, 0, 0, 0, "mode3 R4");
        run_case(0, 1, 1, 2'd2, 16'h4321, 16'hC000, 8'h9A, 8'h37, 0, 0, 8'hBE, 8'hEF, 0, "mode2 odd R5");
        run_case(0, 1, 1, 2'd2, 16'h0000, 16'h0000, 8'hFF, 8'hFE, 0, 0, 8'h01, 8'h80, 0, "mode2 wrap R5");
        run_case(0, 1, 1, 2'd0, 16'h5555, 16'h3000, 8'h00, 8'hFF, 0, 0, 0, 0, 0, "mode0 rst R6");
        run_case(0, 1, 1, 2'd0, 16'hAAAA, 16'h3002, 8'h00, 8'hCD, 8'h34, 8'h12, 0, 0, 0, "mode0 call R7");
        run_case(1, 1, 1, 2'd0, 16'h2468, 16'h4000, 8'h00, 8'hCD, 8'h00, 8'h00, 0, 0, 1, "held boundary R3");
        run_case(0, 1, 1, 2'd2, 16'h1357, 16'h5000, 8'h10, 8'h20, 0, 0, 8'h30, 8'h40, 1, "held mode2 R3");

        for (int i = 0; i < 80; i++) begin
            logic [7:0] ab;
            ab = ($urandom % 3 == 0) ? 8'hCD : 8'($urandom);
            run_case(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0,
                     2'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), ab,
                     8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                     ($urandom % 5) == 0, "random");
        end
        report();
    end

endmodule